// File: doc/BRIEF.md
# SDRAM Maintenance Command Sequencer

This block issues the housekeeping commands that an SDRAM controller must send outside normal data traffic. It serves several chip-select spaces. A per-space mask tells it which spaces hold SDRAM. Each maintenance operation is a pair of commands. An initialization closes every bank and then loads the mode register. A refresh closes every bank and then issues an auto-refresh, also called CAS-before-RAS refresh. Each command goes out in the same cycle to every space marked in the mask.

The sequencer drives the RAS, CAS and WE strobes, the address bus and the chip selects, all active low. It holds no command pin for longer than one cycle. Parameterised idle gaps follow each command: `T_RP` after the precharge-all, `T_MRD` after the mode-set and `T_RC` after the refresh. A pulse on `page_invalidate` tells the access logic to drop its open-page record, so the next access is handled as a page miss.

The init bit is set by reset or by a write pulse, and it clears itself once the mode-set sequence completes. A pending refresh is remembered until it has been served. While the bus is in hold, no new sequence starts.

The states are:
- **ST_IDLE**: goes to ST_PRE when hold is low and an init or a refresh is pending.
- **ST_PRE**: issues the precharge-all command and goes to ST_PRE_WAIT.
- **ST_PRE_WAIT**: idles for `T_RP` cycles, then goes to ST_MRS or ST_REF according to the operation latched at the start.
- **ST_MRS** and **ST_REF**: each issues its command and goes to ST_RECOVER.
- **ST_RECOVER**: idles for `T_MRD` or `T_RC` cycles, pulses `done` in the last of them and returns to ST_IDLE.

Top module: `sdram_maint_seq`

## Requirements
- R1: While reset is low, and on leaving reset, every chip select and every strobe is high, `busy` is 0 and `init_bit` is 1.
- R2: Commands are encoded as {ras_n,cas_n,we_n}: precharge-all = 010, refresh = 001, mode-set = 000, NOP = 111. In a command cycle `cs_n` equals the inverse of `sdram_mask`. In every other cycle `cs_n` is all ones. The address is 0 during a refresh.
- R3: Each refresh and each mode-set comes directly after a precharge-all, with address bit 10 high on the precharge-all. Exactly `T_RP` NOP cycles separate the precharge-all from the command that follows it.
- R4: During a mode-set the address bus carries 0x0030.
- R5: After a mode-set there are `T_MRD` NOP cycles, and after a refresh there are `T_RC` NOP cycles. `done` is high only in the last of these cycles.
- R6: `init_bit` is 1 in the cycle after `init_set` is pulsed. It goes to 0 in the cycle after the `done` of a mode-set sequence.
- R7: When an init and a refresh are both pending, the mode-set sequence runs first and the refresh sequence follows it.
- R8: While `bus_hold` is high no sequence starts; the request stays pending and is served after hold is released.
- R9: `page_invalidate` is high in the precharge-all cycle and in the `done` cycle.
- R10: `busy` is high from the precharge-all cycle through the `done` cycle, and is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| refresh_req | input | 1 | One-cycle pulse asking for one refresh |
| init_set | input | 1 | One-cycle pulse that sets the init bit |
| sdram_mask | input | NUM_CS | Bit per chip-select space, 1 = SDRAM |
| bus_hold | input | 1 | External bus hold is active |
| cs_n | output | NUM_CS | Chip selects, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| page_invalidate | output | 1 | Drop open-page tracking |
| init_bit | output | 1 | Init pending, clears on its own |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Last cycle of a sequence |

## Verification
The assertions rely on a few things about the inputs. `sdram_mask` is stable during a sequence. `bus_hold` is only acted on at the start of a sequence. `refresh_req` never arrives in the same cycle that a pending refresh is being taken. The bench meets these conditions by changing the mask and hold only while the block is idle, and by pulsing requests only between sequences. It then checks every chip-select pattern for refresh, several patterns for initialization, a deferral under hold and a case where init and refresh are pending together.

// File: rtl/sdram_maint_pkg.sv
package sdram_maint_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_PRE_WAIT,
        ST_MRS,
        ST_REF,
        ST_RECOVER
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PREALL,
        CMD_REFRESH,
        CMD_MODESET
    } maint_cmd_e;

    localparam logic [15:0] MODE_WORD = 16'h0030;

endpackage

// File: rtl/maint_gap_timer.sv
module maint_gap_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // The gap counts down by exactly one per cycle (spacing for R3/R5)
    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/maint_pin_drive.sv
module maint_pin_drive
    import sdram_maint_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 13
) (
    input  maint_cmd_e        cmd,
    input  logic [NUM_CS-1:0] sdram_mask,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        cs_n  = '1;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        unique case (cmd)
            CMD_NOP: begin
            end
            CMD_PREALL: begin
                cs_n     = ~sdram_mask;
                ras_n    = 1'b0;
                we_n     = 1'b0;
                addr[10] = 1'b1;
            end
            CMD_REFRESH: begin
                cs_n  = ~sdram_mask;
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MODESET: begin
                cs_n  = ~sdram_mask;
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = ADDR_W'(MODE_WORD);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sdram_maint_seq.sv
module sdram_maint_seq
    import sdram_maint_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 13,
    parameter int T_RP   = 3,
    parameter int T_RC   = 7,
    parameter int T_MRD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_req,
    input  logic              init_set,
    input  logic [NUM_CS-1:0] sdram_mask,
    input  logic              bus_hold,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic              page_invalidate,
    output logic              init_bit,
    output logic              busy,
    output logic              done
);

    localparam int GAP_A   = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int GAP_MAX = (GAP_A > T_MRD) ? GAP_A : T_MRD;
    localparam int CNT_W   = $clog2(GAP_MAX + 1);

    seq_state_e       state, state_nx;
    maint_cmd_e       cmd;
    logic             init_q, ref_pend, op_mrs;
    logic             start, gap_load, gap_done;
    logic [CNT_W-1:0] gap_val;

    // Parameter sanity (R3/R4): the gaps are at least one cycle and bit 10 exists
    initial begin
        assert_params_R3: assert (T_RP >= 1 && T_RC >= 1 && T_MRD >= 1 && ADDR_W >= 11);
    end

    assign start = (state == ST_IDLE) && !bus_hold && (init_q || ref_pend);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_PRE;
            ST_PRE:      state_nx = ST_PRE_WAIT;
            ST_PRE_WAIT: if (gap_done) state_nx = op_mrs ? ST_MRS : ST_REF;
            ST_MRS:      state_nx = ST_RECOVER;
            ST_REF:      state_nx = ST_RECOVER;
            ST_RECOVER:  if (gap_done) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Request bookkeeping: init bit, pending refresh, latched operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q   <= 1'b1;
            ref_pend <= 1'b0;
            op_mrs   <= 1'b0;
        end else begin
            if (init_set)              init_q <= 1'b1;
            else if (done && op_mrs)   init_q <= 1'b0;
            if (refresh_req)           ref_pend <= 1'b1;
            else if (start && !init_q) ref_pend <= 1'b0;
            if (start)                 op_mrs <= init_q;
        end
    end

    // Outputs by state
    always_comb begin
        cmd      = CMD_NOP;
        gap_load = 1'b0;
        gap_val  = '0;
        unique case (state)
            ST_PRE: begin
                cmd      = CMD_PREALL;
                gap_load = 1'b1;
                gap_val  = CNT_W'(T_RP - 1);
            end
            ST_MRS: begin
                cmd      = CMD_MODESET;
                gap_load = 1'b1;
                gap_val  = CNT_W'(T_MRD - 1);
            end
            ST_REF: begin
                cmd      = CMD_REFRESH;
                gap_load = 1'b1;
                gap_val  = CNT_W'(T_RC - 1);
            end
            default: begin
            end
        endcase
    end

    assign done            = (state == ST_RECOVER) && gap_done;
    assign busy            = (state != ST_IDLE);
    assign page_invalidate = (state == ST_PRE) || done;
    assign init_bit        = init_q;

    maint_gap_timer #(.CNT_W(CNT_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_done)
    );

    maint_pin_drive #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_pins (
        .cmd        (cmd),
        .sdram_mask (sdram_mask),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .addr       (addr)
    );

    assert_prefix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n) |-> ($past(ras_n && cas_n && we_n) && $past(gap_done)));

    assert_mode_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n && !we_n) |-> (addr == ADDR_W'(MODE_WORD)));

    assert_select_only_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> !ras_n);

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ras_n && cas_n && we_n && busy));

    assert_hold_defers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(bus_hold));

    assert_init_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_bit) |-> $past(done));

endmodule

// File: tb/sdram_maint_seq_test.sv
module sdram_maint_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCS        = 4;
    localparam int AW         = 13;
    localparam int TRP        = 2;
    localparam int TRC        = 3;
    localparam int TMRD       = 2;

    logic           clk = 1'b0;
    logic           rst_n, refresh_req, init_set, bus_hold;
    logic [NCS-1:0] sdram_mask;
    logic [NCS-1:0] cs_n;
    logic           ras_n, cas_n, we_n;
    logic [AW-1:0]  addr;
    logic           page_invalidate, init_bit, busy, done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_maint_seq #(.NUM_CS(NCS), .ADDR_W(AW), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD)) uut (
        .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .init_set(init_set),
        .sdram_mask(sdram_mask), .bus_hold(bus_hold), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .page_invalidate(page_invalidate),
        .init_bit(init_bit), .busy(busy), .done(done)
    );

    // 0 NOP, 1 precharge-all, 2 refresh, 3 mode-set, 4 illegal
    function automatic int decode();
        case ({ras_n, cas_n, we_n})
            3'b111:  return 0;
            3'b010:  return 1;
            3'b001:  return 2;
            3'b000:  return 3;
            default: return 4;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_refresh();
        @(negedge clk) refresh_req = 1'b1;
        @(negedge clk) refresh_req = 1'b0;
    endtask

    task automatic pulse_init();
        @(negedge clk) init_set = 1'b1;
        @(negedge clk) init_set = 1'b0;
    endtask

    task automatic expect_seq(input bit is_mrs, input logic [NCS-1:0] m);
        int n;
        int code;
        n = 0;
        while (decode() == 0 && n < 50) begin
            @(negedge clk);
            n++;
        end
        code = decode();
        chk(code == 1, "R3 precharge-all first", code, 1);
        chk(cs_n == ~m, "R2 chip selects on precharge", int'(cs_n), int'(~m));
        chk(addr[10] == 1'b1, "R3 addr bit 10", int'(addr[10]), 1);
        chk(page_invalidate == 1'b1, "R9 invalidate on precharge", int'(page_invalidate), 1);
        chk(busy == 1'b1, "R10 busy on precharge", int'(busy), 1);
        n = 0;
        @(negedge clk);
        while (decode() == 0 && n < 50) begin
            chk(cs_n == '1, "R2 idle chip selects", int'(cs_n), 'hF);
            n++;
            @(negedge clk);
        end
        chk(n == TRP, "R3 precharge gap", n, TRP);
        code = decode();
        chk(code == (is_mrs ? 3 : 2), "R3 command after precharge", code, is_mrs ? 3 : 2);
        chk(cs_n == ~m, "R2 chip selects on command", int'(cs_n), int'(~m));
        if (is_mrs) chk(addr == AW'(16'h0030), "R4 mode word", int'(addr), 'h30);
        else        chk(addr == '0, "R2 refresh address", int'(addr), 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            chk(decode() == 0, "R5 quiet recovery", decode(), 0);
        end while (!done && n < 50);
        chk(n == (is_mrs ? TMRD : TRC), "R5 recovery length", n, is_mrs ? TMRD : TRC);
        chk(page_invalidate == 1'b1, "R9 invalidate on done", int'(page_invalidate), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R10 idle after done", int'(busy), 0);
        chk(done == 1'b0, "R5 done single cycle", int'(done), 0);
        if (is_mrs) chk(init_bit == 1'b0, "R6 init bit cleared", int'(init_bit), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R5 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        refresh_req = 1'b0;
        init_set    = 1'b0;
        bus_hold    = 1'b1;
        sdram_mask  = 4'b0101;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == '1 && ras_n && cas_n && we_n, "R1 pins idle in reset", int'(cs_n), 'hF);
        chk(busy == 1'b0, "R1 not busy in reset", int'(busy), 0);
        chk(init_bit == 1'b1, "R1 init bit set by reset", int'(init_bit), 1);
        rst_n = 1'b1;
        // R8 hold defers the reset-time init
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R8 no start under hold", int'(busy), 0);
        chk(cs_n == '1, "R8 no command under hold", int'(cs_n), 'hF);
        chk(init_bit == 1'b1, "R8 init still pending", int'(init_bit), 1);
        bus_hold = 1'b0;
        @(negedge clk);
        expect_seq(1'b1, 4'b0101);

        // Refresh over every chip-select pattern (R2, R3, R5)
        for (int mk = 0; mk < 16; mk++) begin
            sdram_mask = NCS'(mk);
            pulse_refresh();
            expect_seq(1'b0, NCS'(mk));
        end

        // Init by write pulse (R6, R4)
        for (int mk = 1; mk < 16; mk += 5) begin
            sdram_mask = NCS'(mk);
            pulse_init();
            chk(init_bit == 1'b1, "R6 init bit set by write", int'(init_bit), 1);
            expect_seq(1'b1, NCS'(mk));
        end

        // Both pending under hold: init first (R7, R8)
        sdram_mask = 4'b1011;
        bus_hold   = 1'b1;
        pulse_refresh();
        pulse_init();
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R8 both held off", int'(busy), 0);
        bus_hold = 1'b0;
        @(negedge clk);
        expect_seq(1'b1, 4'b1011);
        expect_seq(1'b0, 4'b1011);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0 && init_bit == 1'b0, "R7 nothing left pending", int'(busy), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule